// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire serial converter link. It runs on a fast system clock and produces the converter's serial clock and its conversion strobe. It samples the returning serial data line and assembles each frame's bits into a parallel word. Each word is offered on a valid/ready output. Software-free command pins start and stop continuous conversion. A third command sends the converter into its low-power state, using only the strobe and clock wires.

Once started, the controller runs frames back to back. Each frame opens with a strobe pulse one serial-clock period wide, followed by a fixed number of serial-clock periods. Data bits arrive MSB first, starting from the third serial-clock rising edge of the frame. Each bit is sampled on the following falling edge. A sleep command is taken only while the controller is idle and not running. It produces four strobe pulses with the serial clock held low. A later start first sends one serial-clock period to wake the converter, then waits out a settling interval, and only then begins frames.

The output stream follows valid/ready rules. A word stays valid, with stable data, until it is accepted. While a word is still waiting, no new frame begins: the controller holds both lines low at the frame boundary. No word is ever lost or overwritten.

Top module: `adc_readout_ctrl`

## Requirements
- R1: Every strobe pulse (`adc_conv_o` high) lasts exactly one serial-clock period, 2*DIV system cycles.
- R2: Each serial-clock high phase is exactly DIV system cycles and each low phase at least DIV cycles. Between the strobe rises of two consecutive conversion frames there are exactly FRAME_LEN serial-clock rising edges.
- R3: While running with the output always ready, consecutive frame strobe rises are exactly 2*DIV*FRAME_LEN system cycles apart.
- R4: The word holds the bits present after serial-clock rising edges 3 through DATA_BITS+2 of the frame, counted from 1 at the first rise after the strobe rise. Each bit is sampled before the following falling edge. The first bit is the word's MSB, `out_data_o[DATA_BITS-1]`.
- R5: The strobe stays low for at least one serial-clock period (2*DIV cycles) between any two pulses, for frame pulses and sleep pulses alike.
- R6: A `sleep_i` pulse while idle and not running produces exactly four strobe pulses with no serial-clock edge. After them `asleep_o` reads 1 and both lines stay low.
- R7: `sleep_i` while running has no effect: `asleep_o` stays 0 and frames and words continue.
- R8: `start_i` while asleep gives exactly one serial-clock rising edge before the next strobe rise. At least SETTLE_CYCLES system cycles pass between that edge and the strobe rise. `settling_o` is 1 and `asleep_o` is 0 during the wait.
- R9: `out_valid_o` rises after the last bit of a frame is captured. While `out_ready_i` is 0, valid and data stay unchanged. With `out_ready_i` at 1, valid is high for exactly one cycle per word.
- R10: No frame strobe rises while a word is pending. Every conversion frame yields exactly one accepted word, in order.
- R11: `stop_i` lets the frame in progress complete and deliver its word; after that no strobe rises. `stop_i` overrides a simultaneous `start_i`.
- R12: After reset, `adc_sck_o`, `adc_conv_o`, `out_valid_o`, `asleep_o` and `settling_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin continuous conversion (wakes the converter if asleep) |
| stop_i | input | 1 | End conversion after the current frame |
| sleep_i | input | 1 | Request the converter's low-power state (idle only) |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_conv_o | output | 1 | Conversion strobe to the converter |
| out_valid_o | output | 1 | Sample word valid |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | DATA_BITS | Sample word, MSB first bit received |
| asleep_o | output | 1 | Converter has been put to sleep |
| settling_o | output | 1 | Wake clock or settling wait in progress |

## Verification
The assertions assume that `adc_sdo_i` changes only shortly after a serial-clock rising edge and is therefore stable at the sampling point. They also assume the command pins are synchronous to `clk`. The bench's converter model meets both conditions: it updates the data line on each clock rise of its own input, and every input is driven one nanosecond after a system edge. The output-ready line is driven in two patterns: always high, and high in only one cycle out of 53. The second pattern holds words pending across frame boundaries.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_SLEEP,
    ST_ASLEEP,
    ST_WAKE,
    ST_SETTLE
  } ctl_state_e;

  localparam int LEAD_PERIODS  = 2;  // periods before the first data bit
  localparam int SLEEP_PERIODS = 8;  // four pulses, each high then low
endpackage

// File: rtl/adc_rd_timebase.sv
module adc_rd_timebase #(
  parameter int DIV = 4,
  parameter int PW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  output logic [PW-1:0] pcnt_o,
  output logic          half_hi_o,
  output logic          period_end_o
);
  localparam int HW = (2 * DIV > 2) ? $clog2(2 * DIV) : 1;
  localparam logic [HW-1:0] H_LAST = HW'(2 * DIV - 1);
  localparam logic [HW-1:0] H_MID  = HW'(DIV);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      hcnt   <= '0;
      pcnt_o <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt   <= '0;
      pcnt_o <= pcnt_o + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign half_hi_o    = (hcnt >= H_MID);
  assign period_end_o = (hcnt == H_LAST);

  a_r2_hcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= H_LAST);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int DATA_BITS = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic                 last_i,
  input  logic                 sdo_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic [DATA_BITS-1:0] out_data_o
);
  logic [DATA_BITS-2:0] shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q     <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (sample_i) shift_q <= {shift_q[DATA_BITS-3:0], sdo_i};
      if (sample_i && last_i) begin
        out_data_o  <= {shift_q, sdo_i};
        out_valid_o <= 1'b1;
      end else if (out_valid_o && out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  // R10: a word is never overwritten before it is accepted
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && last_i) |-> !out_valid_o);

  // R9: pending word holds still
  a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV           = 4,
  parameter int FRAME_LEN     = 18,
  parameter int DATA_BITS     = 14,
  parameter int SETTLE_CYCLES = 200000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 sleep_i,
  input  logic                 adc_sdo_i,
  output logic                 adc_sck_o,
  output logic                 adc_conv_o,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [DATA_BITS-1:0] out_data_o,
  output logic                 asleep_o,
  output logic                 settling_o
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [PW-1:0] P_FRAME_LAST = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] P_SLEEP_LAST = PW'(SLEEP_PERIODS - 1);
  localparam logic [PW-1:0] P_BIT_FIRST  = PW'(LEAD_PERIODS);
  localparam logic [PW-1:0] P_BIT_LAST   = PW'(LEAD_PERIODS + DATA_BITS - 1);
  localparam logic [SW-1:0] S_LAST       = SW'(SETTLE_CYCLES - 1);

  ctl_state_e    state, state_n;
  logic          running, running_n;
  logic          tb_clr, period_end, half_hi, stall;
  logic [PW-1:0] pcnt;
  logic [SW-1:0] settle_cnt;
  logic          smp_en, smp_last;
  logic          conv_d, sck_d;

  adc_rd_timebase #(.DIV(DIV), .PW(PW)) tb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (tb_clr),
    .pcnt_o       (pcnt),
    .half_hi_o    (half_hi),
    .period_end_o (period_end)
  );

  assign stall     = out_valid_o && !out_ready_i;
  assign running_n = stop_i ? 1'b0 : (start_i ? 1'b1 : running);

  always_comb begin
    state_n = state;
    tb_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (running_n && !stall) begin
          state_n = ST_FRAME;
          tb_clr  = 1'b1;
        end else if (sleep_i && !running_n) begin
          state_n = ST_SLEEP;
          tb_clr  = 1'b1;
        end
      end
      ST_FRAME: begin
        if (period_end && pcnt == P_FRAME_LAST) begin
          tb_clr = 1'b1;
          if (!running_n || stall) state_n = ST_IDLE;
        end
      end
      ST_SLEEP: begin
        if (period_end && pcnt == P_SLEEP_LAST) state_n = ST_ASLEEP;
      end
      ST_ASLEEP: begin
        if (running_n) begin
          state_n = ST_WAKE;
          tb_clr  = 1'b1;
        end
      end
      ST_WAKE: begin
        if (period_end) state_n = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_cnt == S_LAST) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    conv_d = (state == ST_FRAME && pcnt == '0) ||
             (state == ST_SLEEP && !pcnt[0]);
    sck_d  = (state == ST_FRAME || state == ST_WAKE) && half_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      running    <= 1'b0;
      settle_cnt <= '0;
      adc_conv_o <= 1'b0;
      adc_sck_o  <= 1'b0;
    end else begin
      state      <= state_n;
      running    <= running_n;
      settle_cnt <= (state == ST_SETTLE) ? settle_cnt + 1'b1 : '0;
      adc_conv_o <= conv_d;
      adc_sck_o  <= sck_d;
    end
  end

  assign smp_en   = (state == ST_FRAME) && period_end &&
                    (pcnt >= P_BIT_FIRST) && (pcnt <= P_BIT_LAST);
  assign smp_last = (pcnt == P_BIT_LAST);

  adc_rd_capture #(.DATA_BITS(DATA_BITS)) cap_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (smp_en),
    .last_i      (smp_last),
    .sdo_i       (adc_sdo_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  assign asleep_o   = (state == ST_ASLEEP);
  assign settling_o = (state == ST_WAKE) || (state == ST_SETTLE);

  // R2: a strobe never rises while the serial clock is high
  a_r2_conv_rise_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv_o) |-> !adc_sck_o);

  // R6: no serial-clock activity during the sleep sequence
  a_r6_sck_idle_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP || state == ST_ASLEEP) |-> !adc_sck_o);

  // R8: leaving sleep always goes through the wake clock
  a_r8_wake_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ASLEEP) |-> (state == ST_ASLEEP || state == ST_WAKE));

  // R10: no frame starts while a word waits
  a_r10_no_frame_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_FRAME && state_n == ST_FRAME) |-> !stall);
endmodule

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;
  localparam int DIV = 2;
  localparam int FL  = 18;
  localparam int DB  = 14;
  localparam int S   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, sleep_rq = 1'b0;
  logic sdo = 1'b0, ready = 1'b1;
  logic sck, conv, valid, asleep, settling;
  logic [DB-1:0] data;

  always #10 clk = ~clk;

  adc_readout_ctrl #(.DIV(DIV), .FRAME_LEN(FL), .DATA_BITS(DB), .SETTLE_CYCLES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .sleep_i(sleep_rq),
    .adc_sdo_i(sdo), .adc_sck_o(sck), .adc_conv_o(conv), .out_valid_o(valid),
    .out_ready_i(ready), .out_data_o(data), .asleep_o(asleep), .settling_o(settling)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model
  function automatic logic [DB-1:0] smp(input int n);
    logic [31:0] v;
    if (n == 1) return '1;
    if (n == 2) return '0;
    v = (n * 32'h2B7 + 32'h135) ^ (n << 5);
    return v[DB-1:0];
  endfunction

  logic [DB-1:0] cur = '0;
  int model_n = 0, model_r = 0;
  always @(posedge conv) begin
    cur = smp(model_n);
    model_n++;
    model_r = 0;
  end
  always @(posedge sck) begin
    model_r++;
    if (model_r >= 3 && model_r <= DB + 2) sdo = cur[DB-1-(model_r-3)];
    else sdo = 1'b0;
  end

  // ready pattern
  int rdy_mode = 0;
  longint rc = 0;
  always @(posedge clk) begin
    #1;
    rc++;
    ready = (rdy_mode == 0) ? 1'b1 : ((rc % 53) == 0);
  end

  // monitor
  longint cyc = 0, last_rise = 0, wake_cyc = 0;
  int conv_rises = 0, sck_rises = 0, words = 0;
  int conv_hi = 0, conv_lo = 0, sck_hi = 0, sck_lo = 100, sck_since = 0;
  bit have_conv = 0, wake_armed = 0, spacing_chk = 0;
  logic p_conv = 0, p_sck = 0, p_valid = 0, p_ready = 0, p_hs = 0;
  logic [DB-1:0] p_data = '0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (conv && !p_conv) begin
      conv_rises++;
      if (have_conv) chk(conv_lo >= 2*DIV, "R5 strobe low width", conv_lo, 2*DIV);
      chk(!p_valid, "R10 frame start with word pending", p_valid, 0);
      if (wake_armed) begin
        chk(sck_since == 1, "R8 wake clock edges", sck_since, 1);
        chk(cyc - wake_cyc >= S, "R8 settle gap", cyc - wake_cyc, S);
        wake_armed = 0;
      end else if (sck_since != 0) begin
        chk(sck_since == FL, "R2 rises per frame", sck_since, FL);
        if (spacing_chk)
          chk(cyc - last_rise == 2*DIV*FL, "R3 frame spacing", cyc - last_rise, 2*DIV*FL);
      end
      have_conv = 1; last_rise = cyc; sck_since = 0; conv_hi = 0;
    end
    if (!conv && p_conv) begin
      chk(conv_hi == 2*DIV, "R1 strobe width", conv_hi, 2*DIV);
      conv_lo = 0;
    end
    if (conv) conv_hi++; else conv_lo++;

    if (sck && !p_sck) begin
      sck_rises++; sck_since++;
      if (wake_armed) wake_cyc = cyc;
      chk(sck_lo >= DIV, "R2 sck low phase", sck_lo, DIV);
      sck_hi = 0;
    end
    if (!sck && p_sck) begin
      chk(sck_hi == DIV, "R2 sck high phase", sck_hi, DIV);
      sck_lo = 0;
    end
    if (sck) sck_hi++; else sck_lo++;

    if (p_hs) chk(!valid, "R9 one-cycle valid", valid, 0);
    if (p_valid && !p_ready) begin
      chk(valid == 1'b1, "R9 valid held", valid, 1);
      chk(data == p_data, "R9 data held", data, p_data);
    end
    if (valid && ready) begin
      words++;
      chk(data == cur, "R4 word value", data, cur);
    end
    p_hs = valid && ready && (rdy_mode == 0);
    p_conv = conv; p_sck = sck; p_valid = valid; p_ready = ready; p_data = data;
  end

  task automatic pulse_start();  @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0; endtask
  task automatic pulse_stop();   @(posedge clk); #1 stop = 1;  @(posedge clk); #1 stop = 0;  endtask
  task automatic pulse_sleep();  @(posedge clk); #1 sleep_rq = 1; @(posedge clk); #1 sleep_rq = 0; endtask
  task automatic wait_words(input int n);
    while (words < n) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", words, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w0, c0, s0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(sck == 0, "R12 sck reset", sck, 0);
    chk(conv == 0, "R12 conv reset", conv, 0);
    chk(valid == 0, "R12 valid reset", valid, 0);
    chk(asleep == 0, "R12 asleep reset", asleep, 0);
    chk(settling == 0, "R12 settling reset", settling, 0);

    // phase A: free-running, always ready
    pulse_start();
    wait_words(3);
    spacing_chk = 1;
    wait_words(10);
    w0 = words;
    pulse_sleep();
    repeat (100) @(posedge clk);
    #1;
    chk(asleep == 0, "R7 sleep ignored while running", asleep, 0);
    chk(words > w0, "R7 words continue", words, w0 + 1);
    wait_words(20);
    spacing_chk = 0;

    // stop mid-frame
    @(posedge conv);
    repeat (6) @(posedge clk);
    w0 = words; c0 = conv_rises;
    pulse_stop();
    repeat (200) @(posedge clk);
    #1;
    chk(words - w0 == 1, "R11 frame completes", words - w0, 1);
    chk(conv_rises - c0 == 0, "R11 no strobe after stop", conv_rises - c0, 0);

    // phase B: heavy back-pressure
    rdy_mode = 1;
    pulse_start();
    wait_words(w0 + 11);
    @(posedge clk); #1 stop = 1; start = 0;
    @(posedge clk); #1 stop = 0;
    rdy_mode = 0;
    repeat (300) @(posedge clk);

    // sleep
    c0 = conv_rises; s0 = sck_rises;
    pulse_sleep();
    repeat (200) @(posedge clk);
    #1;
    chk(conv_rises - c0 == 4, "R6 four sleep pulses", conv_rises - c0, 4);
    chk(sck_rises - s0 == 0, "R6 sck idle", sck_rises - s0, 0);
    chk(asleep == 1, "R6 asleep flag", asleep, 1);

    // wake
    wake_armed = 1;
    w0 = words;
    pulse_start();
    repeat (5) @(posedge clk);
    #1;
    chk(settling == 1, "R8 settling flag", settling, 1);
    chk(asleep == 0, "R8 asleep cleared", asleep, 0);
    wait_words(w0 + 4);
    chk(wake_armed == 0, "R8 wake seen", wake_armed, 0);
    pulse_stop();
    repeat (200) @(posedge clk);
    #1;
    chk(conv_rises - 4 == words, "R10 one word per frame", words, conv_rises - 4);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule